// File: doc/BRIEF.md
# Serial Audio Word Transmitter

This block takes parallel audio words over a valid/ready handshake and shifts them out, most significant bit first, on a single serial data line. The line is timed by a bit clock and framed by a frame sync. Both arrive as levels. They come either from a neighbouring on-chip generator, which is used directly, or from device pins, which pass through a synchronizer first. Edges on both are detected in the system clock domain. A set of static configuration inputs controls the serial format:

- the coded word length;
- the number of words per frame;
- the number of bit clocks between the frame sync and the first data bit;
- which bit-clock edge launches data;
- the active level of the frame sync;
- whether a frame sync that arrives during a frame is honoured;
- an enable that holds the transmitter in reset while it is low.

A one-word holding register sits between the handshake and the shifter. When a word slot begins and no word is waiting, the previous word is sent again. A sticky underflow flag records the event, and a clear input resets it.

Top module: `sat_tx`

## Requirements
- R1: `cfg_wlen` selects the bits per word as 0→8, 1→12, 2→16, 3→20, 4→24, 5→32. Only the low N bits of `in_data` are sent, bit N-1 first, one bit per launch edge.
- R2: `cfg_wlen` values 6 and 7 are invalid. No frame starts with them, and `ser_out` stays 0.
- R3: A frame carries `cfg_frame_len`+1 words back to back. After the last bit, `ser_out` returns to 0 at the next launch edge and stays idle until a new frame start.
- R4: With `cfg_delay` = D, the first data bit appears D launch edges after the launch edge that detected the frame start. D = 0 puts it on that same edge. `ser_out` is 0 during the delay.
- R5: While `cfg_en` is low, `ser_out` is 0 from the next cycle on, `in_ready` is low and any held word is dropped. After `cfg_en` rises, nothing is sent before a frame start.
- R6: With `cfg_clk_pol` = 0, data launches on falling bit-clock edges; with 1, on rising edges. `ser_out` changes only in the cycle after a launch edge is seen, or on disable.
- R7: The frame sync is active high when `cfg_fs_pol` = 0 and active low when it is 1. A frame start is an inactive-to-active change between two successive launch edges.
- R8: With `cfg_ign_fs` = 1, a frame start during a frame in progress is ignored. With 0, it restarts the frame at word 0, including the delay.
- R9: With `cfg_ext_clk` = 1, `ext_bclk` and `ext_fs` are used after a two-flop synchronizer, which adds two cycles of latency. With 0, `int_bclk` and `int_fs` are used directly.
- R10: `in_ready` is high exactly when the block is enabled and its one-word holding register is empty. An accepted word is used at the next word slot.
- R11: A word slot that starts with the holding register empty sends the last word again (0 after reset) and sets `underflow`. `underflow` stays set until `underflow_clr` is high in a cycle with no new underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Transmitter enable; low holds it in reset |
| cfg_wlen | input | 3 | Word length code |
| cfg_frame_len | input | FL_W | Words per frame minus one |
| cfg_delay | input | DL_W | Launch edges from frame start to first bit |
| cfg_clk_pol | input | 1 | 0: launch on falling bit-clock edge, 1: rising |
| cfg_fs_pol | input | 1 | 0: frame sync active high, 1: active low |
| cfg_ign_fs | input | 1 | Ignore frame starts during a frame |
| cfg_ext_clk | input | 1 | 1: use synchronized external clock and sync |
| int_bclk | input | 1 | On-chip bit clock level |
| int_fs | input | 1 | On-chip frame sync level |
| ext_bclk | input | 1 | Pin bit clock level |
| ext_fs | input | 1 | Pin frame sync level |
| in_valid | input | 1 | Word offered |
| in_data | input | DATA_W | Word to send, low N bits used |
| underflow_clr | input | 1 | Clears the sticky underflow flag |
| in_ready | output | 1 | Holding register can take a word |
| ser_out | output | 1 | Serial data line |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The hardest situation to reach is a frame sync that lands while a frame is still shifting. The bench gets there by driving a frame period shorter than the programmed frame, so every second sync falls mid-word. It runs this pattern once with the ignore option set and once with it clear. Two other cases depend on timing across several edges. One is a disable in the middle of a frame, followed by re-enable while the frame sync is already active. The other is word starvation, produced by offering fewer words than slots. A behavioural model driven by the same bit-clock and sync levels, delayed by two cycles in external mode, predicts all three outputs on every cycle.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int CNT_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_SHIFT = 2'd2
    } sat_state_e;

    // coded word length to bit count, 0 for invalid codes
    function automatic logic [CNT_W-1:0] wlen_decode(input logic [2:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            3'd0:    n = 6'd8;
            3'd1:    n = 6'd12;
            3'd2:    n = 6'd16;
            3'd3:    n = 6'd20;
            3'd4:    n = 6'd24;
            3'd5:    n = 6'd32;
            default: n = 6'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sat_edge_sync.sv
module sat_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode,
    input  logic launch_pol,
    input  logic int_bclk,
    input  logic int_fs,
    input  logic ext_bclk,
    input  logic ext_fs,
    output logic launch,
    output logic fs_lvl
);

    logic [STAGES-1:0][1:0] chain_q;
    logic                   bclk_prev_q;
    logic [1:0]             sel_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= {ext_bclk, ext_fs};
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sel_w = ext_mode ? chain_q[STAGES-1] : {int_bclk, int_fs};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_prev_q <= 1'b0;
        else        bclk_prev_q <= sel_w[1];
    end

    assign launch = launch_pol ? (sel_w[1] & ~bclk_prev_q)
                               : (~sel_w[1] & bclk_prev_q);
    assign fs_lvl = sel_w[0];

endmodule

// File: rtl/sat_hold.sv
module sat_hold #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              take,
    output logic              in_ready,
    output logic              hold_vld,
    output logic [DATA_W-1:0] hold_data
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    assign in_ready = en & ~hold_q.vld;

    always_comb begin
        hold_d = hold_q;
        if (!en) begin
            hold_d.vld = 1'b0;
        end else begin
            if (take) hold_d.vld = 1'b0;
            if (in_valid && in_ready) begin
                hold_d.vld  = 1'b1;
                hold_d.data = in_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign hold_vld  = hold_q.vld;
    assign hold_data = hold_q.data;

endmodule

// File: rtl/sat_serializer.sv
module sat_serializer
    import sat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FL_W   = 3,
    parameter int DL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [2:0]        wlen,
    input  logic [FL_W-1:0]   frame_len,
    input  logic [DL_W-1:0]   delay,
    input  logic              fs_pol,
    input  logic              ign_fs,
    input  logic              launch,
    input  logic              fs_lvl,
    input  logic              hold_vld,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              uf_clr,
    output logic              take,
    output logic              ser_out,
    output logic              underflow
);

    typedef struct packed {
        sat_state_e        state;
        logic              ser;
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  bits;
        logic [FL_W-1:0]   widx;
        logic [DL_W-1:0]   dcnt;
        logic [DATA_W-1:0] last;
        logic              uf;
        logic              fs_seen;
    } ser_t;

    ser_t ser_d, ser_q;

    logic [CNT_W-1:0]  n_bits;
    logic              code_ok;
    logic              fs_act;
    logic              start;
    logic              busy;
    logic [CNT_W-1:0]  shamt;
    logic [DATA_W-1:0] word_src;
    logic [DATA_W-1:0] aligned;
    logic              do_load;
    logic              uf_set;

    assign n_bits   = wlen_decode(wlen);
    assign code_ok  = (n_bits != '0);
    assign fs_act   = fs_lvl ^ fs_pol;
    assign start    = launch & fs_act & ~ser_q.fs_seen & code_ok;
    assign busy     = (ser_q.state != ST_IDLE);
    assign shamt    = CNT_W'(DATA_W) - n_bits;
    assign word_src = hold_vld ? hold_data : ser_q.last;
    assign aligned  = word_src << shamt;

    always_comb begin
        ser_d   = ser_q;
        do_load = 1'b0;
        take    = 1'b0;
        uf_set  = 1'b0;

        if (launch) ser_d.fs_seen = fs_act;

        if (!en) begin
            ser_d.state = ST_IDLE;
            ser_d.ser   = 1'b0;
            ser_d.widx  = '0;
            ser_d.dcnt  = '0;
            ser_d.bits  = '0;
        end else if (launch) begin
            if (start && (!busy || !ign_fs)) begin
                ser_d.widx = '0;
                if (delay == '0) begin
                    do_load = 1'b1;
                end else begin
                    ser_d.state = ST_DELAY;
                    ser_d.dcnt  = delay - DL_W'(1);
                    ser_d.ser   = 1'b0;
                end
            end else begin
                case (ser_q.state)
                    ST_DELAY: begin
                        if (ser_q.dcnt == '0) begin
                            do_load = 1'b1;
                        end else begin
                            ser_d.dcnt = ser_q.dcnt - DL_W'(1);
                            ser_d.ser  = 1'b0;
                        end
                    end
                    ST_SHIFT: begin
                        if (ser_q.bits != '0) begin
                            ser_d.ser  = ser_q.sh[DATA_W-1];
                            ser_d.sh   = ser_q.sh << 1;
                            ser_d.bits = ser_q.bits - CNT_W'(1);
                        end else if (ser_q.widx < frame_len) begin
                            ser_d.widx = ser_q.widx + FL_W'(1);
                            do_load    = 1'b1;
                        end else begin
                            ser_d.state = ST_IDLE;
                            ser_d.ser   = 1'b0;
                        end
                    end
                    default: ser_d.ser = 1'b0;
                endcase
            end
        end

        if (do_load) begin
            ser_d.state = ST_SHIFT;
            ser_d.ser   = aligned[DATA_W-1];
            ser_d.sh    = aligned << 1;
            ser_d.bits  = n_bits - CNT_W'(1);
            ser_d.last  = word_src;
            take        = hold_vld;
            uf_set      = ~hold_vld;
        end

        ser_d.uf = (ser_q.uf & ~uf_clr) | uf_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assign ser_out   = ser_q.ser;
    assign underflow = ser_q.uf;

endmodule

// File: rtl/sat_tx.sv
module sat_tx #(
    parameter int DATA_W      = 32,
    parameter int FL_W        = 3,
    parameter int DL_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [2:0]        cfg_wlen,
    input  logic [FL_W-1:0]   cfg_frame_len,
    input  logic [DL_W-1:0]   cfg_delay,
    input  logic              cfg_clk_pol,
    input  logic              cfg_fs_pol,
    input  logic              cfg_ign_fs,
    input  logic              cfg_ext_clk,
    input  logic              int_bclk,
    input  logic              int_fs,
    input  logic              ext_bclk,
    input  logic              ext_fs,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              underflow_clr,
    output logic              in_ready,
    output logic              ser_out,
    output logic              underflow
);

    logic              launch_w;
    logic              fs_lvl_w;
    logic              hold_vld_w;
    logic [DATA_W-1:0] hold_data_w;
    logic              take_w;

    sat_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_mode   (cfg_ext_clk),
        .launch_pol (cfg_clk_pol),
        .int_bclk   (int_bclk),
        .int_fs     (int_fs),
        .ext_bclk   (ext_bclk),
        .ext_fs     (ext_fs),
        .launch     (launch_w),
        .fs_lvl     (fs_lvl_w)
    );

    sat_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .take      (take_w),
        .in_ready  (in_ready),
        .hold_vld  (hold_vld_w),
        .hold_data (hold_data_w)
    );

    sat_serializer #(.DATA_W(DATA_W), .FL_W(FL_W), .DL_W(DL_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_en),
        .wlen      (cfg_wlen),
        .frame_len (cfg_frame_len),
        .delay     (cfg_delay),
        .fs_pol    (cfg_fs_pol),
        .ign_fs    (cfg_ign_fs),
        .launch    (launch_w),
        .fs_lvl    (fs_lvl_w),
        .hold_vld  (hold_vld_w),
        .hold_data (hold_data_w),
        .uf_clr    (underflow_clr),
        .take      (take_w),
        .ser_out   (ser_out),
        .underflow (underflow)
    );

endmodule

// File: rtl/sat_tx_chk.sv
module sat_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic in_valid,
    input logic in_ready,
    input logic ser_out,
    input logic underflow,
    input logic underflow_clr,
    input logic launch
);

    // R5
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !ser_out);

    // R6
    launch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !launch) |=> $stable(ser_out));

    // R10
    one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R11
    uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !underflow_clr) |=> underflow);

    // R11
    uf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_clr && !launch) |=> !underflow);

endmodule

bind sat_tx sat_tx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_en        (cfg_en),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .ser_out       (ser_out),
    .underflow     (underflow),
    .underflow_clr (underflow_clr),
    .launch        (launch_w)
);

// File: tb/sim_sat_tx.sv
module sim_sat_tx;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        cfg_en, cfg_clk_pol, cfg_fs_pol, cfg_ign_fs, cfg_ext_clk;
    logic [2:0]  cfg_wlen, cfg_frame_len;
    logic [1:0]  cfg_delay;
    logic        int_bclk, int_fs, ext_bclk, ext_fs;
    logic        in_valid, underflow_clr;
    logic [31:0] in_data;
    logic        in_ready, ser_out, underflow;

    sat_tx u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wlen(cfg_wlen),
        .cfg_frame_len(cfg_frame_len), .cfg_delay(cfg_delay),
        .cfg_clk_pol(cfg_clk_pol), .cfg_fs_pol(cfg_fs_pol),
        .cfg_ign_fs(cfg_ign_fs), .cfg_ext_clk(cfg_ext_clk),
        .int_bclk(int_bclk), .int_fs(int_fs), .ext_bclk(ext_bclk),
        .ext_fs(ext_fs), .in_valid(in_valid), .in_data(in_data),
        .underflow_clr(underflow_clr), .in_ready(in_ready),
        .ser_out(ser_out), .underflow(underflow)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R5";

    // stimulus for the next edge
    logic  b_bclk = 0, b_fs = 0, b_en = 0, b_clr = 0;
    bit    gap_mode = 0;
    int    step_no = 0;
    logic [31:0] words[$];

    // behavioural reference state
    int          m_state = 0;   // 0 idle, 1 delay, 2 shifting
    int          m_bits = 0, m_widx = 0, m_dcnt = 0;
    logic [31:0] m_word = 0, m_last = 0, m_hold = 0;
    logic        m_hv = 0, m_ser = 0, m_uf = 0, m_seen = 0, m_prev = 0, m_rdy = 0;
    logic [1:0]  m_s1 = 0, m_s2 = 0;
    bit          m_ufset;

    function automatic int word_bits(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            3'd5: return 32;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at step %0d: actual=%b expected=%b", req, what, step_no, act, exp);
        end
    endtask

    task automatic m_load();
        int n;
        n = word_bits(cfg_wlen);
        if (m_hv) begin
            m_word = m_hold;
            m_hv   = 0;
        end else begin
            m_word  = m_last;
            m_ufset = 1;
        end
        m_last  = m_word;
        m_bits  = n - 1;
        m_ser   = m_word[n-1];
        m_state = 2;
    endtask

    task automatic step();
        logic sb, sf, launch, fact, start, hv_old, acc, vld;
        @(negedge clk);
        check(cur_req, "ser_out", ser_out, m_ser);
        check("R10", "in_ready", in_ready, m_rdy);
        check("R11", "underflow", underflow, m_uf);
        step_no++;

        vld = (words.size() > 0) && (!gap_mode || (step_no % 5 == 0));
        cfg_en = b_en; underflow_clr = b_clr;
        int_bclk = b_bclk; ext_bclk = b_bclk; int_fs = b_fs; ext_fs = b_fs;
        in_valid = vld;
        in_data  = vld ? words[0] : 32'h0;

        // reference update for the coming edge
        sb = cfg_ext_clk ? m_s2[1] : b_bclk;
        sf = cfg_ext_clk ? m_s2[0] : b_fs;
        m_s2 = m_s1;
        m_s1 = {b_bclk, b_fs};
        launch = cfg_clk_pol ? (sb && !m_prev) : (!sb && m_prev);
        m_prev = sb;
        fact   = sf ^ cfg_fs_pol;
        start  = launch && fact && !m_seen && (word_bits(cfg_wlen) != 0);
        if (launch) m_seen = fact;
        hv_old  = m_hv;
        m_ufset = 0;
        if (!b_en) begin
            m_state = 0; m_ser = 0; m_widx = 0; m_hv = 0;
        end else if (launch) begin
            if (start && (m_state == 0 || !cfg_ign_fs)) begin
                m_widx = 0;
                if (cfg_delay == 0) m_load();
                else begin m_state = 1; m_dcnt = int'(cfg_delay) - 1; m_ser = 0; end
            end else if (m_state == 1) begin
                if (m_dcnt == 0) m_load();
                else begin m_dcnt--; m_ser = 0; end
            end else if (m_state == 2) begin
                if (m_bits > 0) begin
                    m_ser = m_word[m_bits-1];
                    m_bits--;
                end else if (m_widx < int'(cfg_frame_len)) begin
                    m_widx++;
                    m_load();
                end else begin
                    m_state = 0; m_ser = 0;
                end
            end else begin
                m_ser = 0;
            end
        end
        acc = b_en && vld && !hv_old;
        if (acc) begin
            m_hold = words.pop_front();
            m_hv   = 1;
        end
        m_uf  = (m_uf && !b_clr) || m_ufset;
        m_rdy = b_en && !m_hv;
    endtask

    // bit-clock and frame-sync pattern: nbits bits, period pbits, half period h cycles
    task automatic run(input int nbits, input int pbits, input int h, input int act_bits);
        for (int b = 0; b < nbits; b++) begin
            b_bclk = 1;
            b_fs   = ((b % pbits) < act_bits) ^ cfg_fs_pol;
            for (int k = 0; k < h; k++) step();
            b_bclk = 0;
            for (int k = 0; k < h; k++) step();
        end
    endtask

    task automatic setup(input logic [2:0] wl, input logic [2:0] fl, input logic [1:0] dl,
                         input logic cp, input logic fp, input logic ig, input logic ex);
        b_en = 0;
        for (int k = 0; k < 4; k++) step();
        cfg_wlen = wl; cfg_frame_len = fl; cfg_delay = dl;
        cfg_clk_pol = cp; cfg_fs_pol = fp; cfg_ign_fs = ig; cfg_ext_clk = ex;
        b_fs = fp;
        for (int k = 0; k < 4; k++) step();
        b_en = 1;
    endtask

    task automatic push(input int n, input logic [31:0] seed);
        for (int i = 0; i < n; i++) words.push_back(seed ^ (32'h9E37_79B9 * (i + 1)));
    endtask

    initial begin
        rst_n = 0;
        cfg_en = 0; cfg_wlen = 3'd2; cfg_frame_len = 3'd1; cfg_delay = 2'd1;
        cfg_clk_pol = 0; cfg_fs_pol = 0; cfg_ign_fs = 0; cfg_ext_clk = 0;
        int_bclk = 0; int_fs = 0; ext_bclk = 0; ext_fs = 0;
        in_valid = 0; in_data = 0; underflow_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R5 reset state: idle line, not ready while disabled, no underflow
        cur_req = "R5";
        for (int k = 0; k < 3; k++) step();

        // R1 R3 R4 R7: 16-bit stereo, one-bit delay, active-low sync
        cur_req = "R1 R3 R4 R7";
        setup(3'd2, 3'd1, 2'd1, 0, 1, 0, 0);
        push(6, 32'h1234_A5C3);
        run(120, 40, 2, 20);
        words.delete();

        // R1 R3 R4 R6: 8-bit, four words, zero delay, rising launch edge
        cur_req = "R1 R3 R4 R6";
        setup(3'd0, 3'd3, 2'd0, 1, 0, 0, 0);
        push(8, 32'hC0DE_0F1E);
        run(80, 40, 2, 10);
        words.delete();

        // R1 R4: 32-bit mono, two-bit delay
        cur_req = "R1 R4";
        setup(3'd5, 3'd0, 2'd2, 0, 0, 0, 0);
        push(3, 32'h8BAD_F00D);
        run(80, 40, 2, 20);
        words.delete();

        // R1 remaining lengths 12, 20, 24 with a one-cycle half period
        cur_req = "R1";
        for (int c = 1; c <= 4; c++) begin
            if (c == 2) continue;
            setup(3'(c), 3'd1, 2'd1, 0, 1, 0, 0);
            push(4, 32'h5A5A_3C3C + c);
            run(112, 56, 1, 28);
            words.delete();
        end

        // R2: invalid word-length codes keep the line idle
        cur_req = "R2";
        for (int c = 6; c <= 7; c++) begin
            setup(3'(c), 3'd1, 2'd1, 0, 1, 0, 0);
            push(2, 32'hFFFF_FFFF);
            run(80, 40, 2, 20);
            words.delete();
        end

        // R11: starvation re-sends the last word, then clear
        cur_req = "R11";
        setup(3'd2, 3'd1, 2'd1, 0, 1, 0, 0);
        push(1, 32'h0000_B00F);
        run(80, 40, 2, 20);
        b_clr = 1; step(); b_clr = 0;
        for (int k = 0; k < 6; k++) step();

        // R10: sparse offers through the handshake
        cur_req = "R10";
        gap_mode = 1;
        setup(3'd0, 3'd1, 2'd0, 0, 0, 0, 0);
        push(10, 32'h7777_1357);
        run(120, 30, 2, 15);
        gap_mode = 0;
        words.delete();
        b_clr = 1; step(); b_clr = 0;

        // R8: frame period shorter than the frame, ignore set then clear
        cur_req = "R8";
        setup(3'd2, 3'd1, 2'd0, 0, 0, 1, 0);
        push(8, 32'h2468_ACE0);
        run(60, 20, 2, 10);
        words.delete();
        setup(3'd2, 3'd1, 2'd0, 0, 0, 0, 0);
        push(8, 32'h1357_9BDF);
        run(60, 20, 2, 10);
        words.delete();

        // R9: external clock and sync through the synchronizer
        cur_req = "R9";
        setup(3'd2, 3'd1, 2'd1, 0, 1, 0, 1);
        push(6, 32'hFACE_0123);
        run(120, 40, 2, 20);
        words.delete();

        // R5: disable mid-frame, re-enable while the sync is active
        cur_req = "R5";
        setup(3'd2, 3'd1, 2'd1, 0, 0, 0, 0);
        push(8, 32'h0BAD_CAFE);
        run(50, 40, 2, 20);
        b_en = 0;
        for (int k = 0; k < 6; k++) step();
        b_en = 1;
        run(90, 40, 2, 20);
        words.delete();
        b_clr = 1; step(); b_clr = 0;
        step();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R5 watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule